// File: doc/BRIEF.md
# Shift-and-Add Transposed FIR Filter with Carry-Save Delay Line

This block is a five-tap low-pass FIR filter with fixed coefficients and no multipliers. Each coefficient is a short signed-power-of-two sum. The product of a coefficient and the current sample is therefore a handful of arithmetically shifted copies of that sample, and some of those copies are subtracted. The filter uses the transposed structure: every tap sees the newest sample. Each tap folds its shifted copies into the running partial result that arrives from its upstream neighbour, then registers that result for the next tap.

The running result never leaves redundant form inside the chain. It travels as a carry word and a sum word, and each tap reduces its operands with carry-save adders only. The register-to-register path therefore does not grow with the word width or with the number of taps. A segmented carry-propagate adder, pipelined over a configurable number of stages, turns the final carry/sum pair into a binary result. A parameter can remove that adder and leave only the redundant pair at the outputs.

The input is a signed integer sample qualified by a valid strobe. Every filter register moves only on a valid sample, so gaps in the stream do not disturb the filter history.

Top module: `fir_csd_transposed`

## Requirements
- R1: After reset, a single valid sample of value 16384 followed by valid zero samples produces `out_y` values 402, 3840, 7900, 3840, 402 and then 0, in that order, one value per valid output.
- R2: Each valid output `out_y` (signed, OW = W+2 bits) equals floor((402·x0 + 3840·x1 + 7900·x2 + 3840·x3 + 402·x4) / 16384). Here x0 is the newest valid sample and x1..x4 are the four valid samples before it, counted since reset. Samples are signed two's complement.
- R3: A constant input held for at least five valid samples produces that same constant at the output (unity DC gain), for both positive and negative values.
- R4: While `in_valid` is low, `red_carry`, `red_sum` and the filter history do not change, whatever value `in_sample` carries.
- R5: `red_valid` is high in the cycle after each cycle in which `in_valid` was high, and low otherwise. `out_valid` repeats `red_valid` exactly CPA_STAGES cycles later.
- R6: After each valid sample, `red_carry + red_sum` modulo 2^IW (IW = W+16) equals the untruncated 2^14-scaled result: the numerator of R2 as a two's complement value.
- R7: A synchronous `rst` held over a clock edge clears `red_carry`, `red_sum`, `red_valid`, `out_valid` and `out_y` to zero. It also empties the filter history, so the next response starts from zeros.
- R8: The full-scale inputs +32767 and −32768, held constant or alternating, give outputs that match R2 with no wrap-around.
- R9: With USE_CPA = 0, `out_valid` and `out_y` stay at zero, and the redundant pair equals that of a configuration that has the adder.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_sample` for this cycle |
| in_sample | input | W | Signed input sample |
| red_valid | output | 1 | Redundant result pair holds a new value |
| red_carry | output | W+16 | Carry word of the final tap, 14 fractional bits |
| red_sum | output | W+16 | Sum word of the final tap, 14 fractional bits |
| out_valid | output | 1 | `out_y` holds a new result |
| out_y | output | W+2 | Binary result, truncated to integer units |

## Verification
The hardest condition to reach is a valid sample arriving while the segmented adder still holds results from earlier samples, mixed with idle gaps and a reset that lands in the middle of the stream. The stimulus interleaves bursts of back-to-back samples with random-length gaps that carry junk on `in_sample`. It also asserts reset right after a burst of large values, so the history and the adder stages must both be discarded. Full-scale constant and alternating patterns push the inverted terms and their correction constants to the most negative and most positive sums.

// File: rtl/fir_csd_pkg.sv
package fir_csd_pkg;

  localparam int TAPS   = 5;
  localparam int MAXDIG = 4;
  localparam int SHW    = 4;

  // Right-shift amounts, digit d at [d*SHW +: SHW]
  function automatic logic [MAXDIG*SHW-1:0] tap_shifts(input int t);
    case (t)
      0, 4:    return {4'd13, 4'd10, 4'd7, 4'd5};
      1, 3:    return {4'd0, 4'd0, 4'd6, 4'd2};
      default: return {4'd12, 4'd9, 4'd6, 4'd1};
    endcase
  endfunction

  function automatic int tap_ndig(input int t);
    case (t)
      1, 3:    return 2;
      default: return 4;
    endcase
  endfunction

  // Bit d set: digit d is subtracted
  function automatic logic [MAXDIG-1:0] tap_negs(input int t);
    case (t)
      2:       return 4'b1110;
      default: return 4'b0010;
    endcase
  endfunction

  function automatic int neg_count(input logic [MAXDIG-1:0] m, input int n);
    int k;
    k = 0;
    for (int i = 0; i < MAXDIG; i++)
      if (i < n && m[i]) k++;
    return k;
  endfunction

endpackage

// File: rtl/fir_csd_tap.sv
module fir_csd_tap
  import fir_csd_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 14,
  parameter int GROW = 2,
  parameter logic [MAXDIG*SHW-1:0] SHIFTS = '0,
  parameter logic [MAXDIG-1:0] NEGS = '0,
  parameter int NDIG = 1,
  parameter bit HAS_PREV = 1'b1,
  localparam int IW = W + FRAC + GROW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [W-1:0]  x,
  input  logic [IW-1:0] prev_c,
  input  logic [IW-1:0] prev_s,
  output logic [IW-1:0] c_q,
  output logic [IW-1:0] s_q
);

  localparam int NNEG = neg_count(NEGS, NDIG);

  function automatic logic [IW-1:0] csa_s(input logic [IW-1:0] a, b, c);
    return a ^ b ^ c;
  endfunction

  function automatic logic [IW-1:0] csa_c(input logic [IW-1:0] a, b, c);
    return ((a & b) | (a & c) | (b & c)) << 1;
  endfunction

  // Sample aligned to FRAC fractional bits, shifted, optionally inverted
  function automatic logic [IW-1:0] pp_term(input logic [W-1:0] xi, input int sh,
                                            input logic neg);
    logic signed [IW-1:0] w;
    w = $signed({{GROW{xi[W-1]}}, xi, {FRAC{1'b0}}});
    w = w >>> sh;
    return neg ? ~w : w;
  endfunction

  logic [IW-1:0] s_acc, c_acc, s_nxt, c_nxt, term, corr;
  logic [IW-1:0] tap_s, tap_c;

  always_comb begin
    s_acc = prev_s & {IW{HAS_PREV}};
    c_acc = prev_c & {IW{HAS_PREV}};
    for (int d = 0; d < MAXDIG; d++) begin
      if (d < NDIG) begin
        term  = pp_term(x, int'(SHIFTS[d*SHW +: SHW]), NEGS[d]);
        s_nxt = csa_s(s_acc, c_acc, term);
        c_nxt = csa_c(s_acc, c_acc, term);
        s_acc = s_nxt;
        c_acc = c_nxt;
      end
    end
    corr  = IW'(NNEG);
    term  = '0;
    s_nxt = '0;
    c_nxt = '0;
    tap_s = csa_s(s_acc, c_acc, corr);
    tap_c = csa_c(s_acc, c_acc, corr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= '0;
      s_q <= '0;
    end else if (en) begin
      c_q <= tap_c;
      s_q <= tap_s;
    end
  end

endmodule

// File: rtl/fir_csd_cpa.sv
module fir_csd_cpa #(
  parameter int IW     = 32,
  parameter int OW     = 18,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [IW-1:0] in_c,
  input  logic [IW-1:0] in_s,
  output logic          out_valid,
  output logic [OW-1:0] out_y
);

  localparam int SEG = (IW + STAGES - 1) / STAGES;
  localparam int PW  = SEG * STAGES;

  logic [PW-1:0] a_st  [STAGES];
  logic [PW-1:0] b_st  [STAGES];
  logic          cy_st [STAGES];
  logic [PW-1:0] r_st  [STAGES+1];
  logic          v_st  [STAGES+1];

  assign a_st[0]  = PW'(in_c);
  assign b_st[0]  = PW'(in_s);
  assign cy_st[0] = 1'b0;
  assign r_st[0]  = '0;
  assign v_st[0]  = in_valid;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [SEG:0]  seg_sum;
    logic [PW-1:0] r_next;
    logic [PW-1:0] r_q;
    logic          v_q;

    assign seg_sum = {1'b0, a_st[i][i*SEG +: SEG]} + {1'b0, b_st[i][i*SEG +: SEG]}
                   + {{SEG{1'b0}}, cy_st[i]};

    always_comb begin
      r_next = r_st[i];
      r_next[i*SEG +: SEG] = seg_sum[SEG-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        r_q <= '0;
        v_q <= 1'b0;
      end else begin
        r_q <= r_next;
        v_q <= v_st[i];
      end
    end

    assign r_st[i+1] = r_q;
    assign v_st[i+1] = v_q;

    if (i < STAGES - 1) begin : g_fwd
      logic [PW-1:0] a_q, b_q;
      logic          cy_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          a_q  <= '0;
          b_q  <= '0;
          cy_q <= 1'b0;
        end else begin
          a_q  <= a_st[i];
          b_q  <= b_st[i];
          cy_q <= seg_sum[SEG];
        end
      end
      assign a_st[i+1]  = a_q;
      assign b_st[i+1]  = b_q;
      assign cy_st[i+1] = cy_q;
    end else begin : g_last
      logic carry_unused;
      assign carry_unused = seg_sum[SEG];
    end
  end

  logic cpa_unused;
  assign cpa_unused = ^{a_st[STAGES-1], b_st[STAGES-1], r_st[STAGES]};

  assign out_y     = r_st[STAGES][IW-1 -: OW];
  assign out_valid = v_st[STAGES];

endmodule

// File: rtl/fir_csd_transposed.sv
module fir_csd_transposed
  import fir_csd_pkg::*;
#(
  parameter int W          = 16,
  parameter int FRAC       = 14,
  parameter int GROW       = 2,
  parameter int CPA_STAGES = 2,
  parameter bit USE_CPA    = 1'b1,
  localparam int IW = W + FRAC + GROW,
  localparam int OW = W + GROW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [W-1:0]  in_sample,
  output logic          red_valid,
  output logic [IW-1:0] red_carry,
  output logic [IW-1:0] red_sum,
  output logic          out_valid,
  output logic [OW-1:0] out_y
);

  logic [IW-1:0] c_chain [TAPS];
  logic [IW-1:0] s_chain [TAPS];
  logic          sample_take;
  logic          red_valid_q;

  assign sample_take = in_valid;

  // Tap TAPS-1 starts the chain; tap 0 produces the result
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    localparam int NXT = (t == TAPS - 1) ? t : t + 1;
    fir_csd_tap #(
      .W(W), .FRAC(FRAC), .GROW(GROW),
      .SHIFTS(tap_shifts(t)),
      .NEGS(tap_negs(t)),
      .NDIG(tap_ndig(t)),
      .HAS_PREV(t != TAPS - 1)
    ) u_tap (
      .clk(clk),
      .rst(rst),
      .en(sample_take),
      .x(in_sample),
      .prev_c(c_chain[NXT]),
      .prev_s(s_chain[NXT]),
      .c_q(c_chain[t]),
      .s_q(s_chain[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) red_valid_q <= 1'b0;
    else     red_valid_q <= sample_take;
  end

  assign red_valid = red_valid_q;
  assign red_carry = c_chain[0];
  assign red_sum   = s_chain[0];

  if (USE_CPA) begin : g_cpa
    fir_csd_cpa #(.IW(IW), .OW(OW), .STAGES(CPA_STAGES)) u_cpa (
      .clk(clk),
      .rst(rst),
      .in_valid(red_valid_q),
      .in_c(c_chain[0]),
      .in_s(s_chain[0]),
      .out_valid(out_valid),
      .out_y(out_y)
    );
  end else begin : g_nocpa
    assign out_valid = 1'b0;
    assign out_y     = '0;
  end

endmodule

// File: rtl/fir_csd_chk.sv
module fir_csd_chk #(
  parameter int W          = 16,
  parameter int FRAC       = 14,
  parameter int GROW       = 2,
  parameter int CPA_STAGES = 2,
  parameter bit USE_CPA    = 1'b1,
  localparam int IW = W + FRAC + GROW,
  localparam int OW = W + GROW
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          red_valid,
  input logic [IW-1:0] red_carry,
  input logic [IW-1:0] red_sum,
  input logic          out_valid,
  input logic [OW-1:0] out_y
);

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (red_carry == '0 && red_sum == '0 && !red_valid && !out_valid));

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> red_valid);

  // R5
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !red_valid);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(red_carry) && $stable(red_sum)));

  if (USE_CPA) begin : g_cpa_chk
    logic [IW-1:0] pair_total;
    logic          chk_unused_lo;
    logic [OW-1:0] dy_q [CPA_STAGES];
    logic          dv_q [CPA_STAGES];

    assign pair_total    = red_carry + red_sum;
    assign chk_unused_lo = ^pair_total[IW-OW-1:0];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < CPA_STAGES; i++) begin
          dy_q[i] <= '0;
          dv_q[i] <= 1'b0;
        end
      end else begin
        dy_q[0] <= pair_total[IW-1 -: OW];
        dv_q[0] <= red_valid;
        for (int i = 1; i < CPA_STAGES; i++) begin
          dy_q[i] <= dy_q[i-1];
          dv_q[i] <= dv_q[i-1];
        end
      end
    end

    // R5
    cpa_latency_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid == dv_q[CPA_STAGES-1]);

    // R2
    cpa_result_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_y == dy_q[CPA_STAGES-1]);
  end else begin : g_nocpa_chk
    // R9
    bypass_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!out_valid && out_y == '0));
  end

endmodule

bind fir_csd_transposed fir_csd_chk #(
  .W(W), .FRAC(FRAC), .GROW(GROW), .CPA_STAGES(CPA_STAGES), .USE_CPA(USE_CPA)
) chk_i (
  .clk(clk),
  .rst(rst),
  .in_valid(in_valid),
  .red_valid(red_valid),
  .red_carry(red_carry),
  .red_sum(red_sum),
  .out_valid(out_valid),
  .out_y(out_y)
);

// File: tb/fir_csd_transposed_tb_top.sv
`timescale 1ns/1ps
module fir_csd_transposed_tb_top;

  localparam int W   = 16;
  localparam int CPA = 2;
  localparam int IW  = W + 16;
  localparam int OW  = W + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_sample = '0;
  logic          red_valid, out_valid;
  logic [IW-1:0] red_carry, red_sum;
  logic [OW-1:0] out_y;
  logic          b_red_valid, b_out_valid;
  logic [IW-1:0] b_red_carry, b_red_sum;
  logic [OW-1:0] b_out_y;

  always #4 clk = ~clk;

  fir_csd_transposed #(.W(W), .CPA_STAGES(CPA), .USE_CPA(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .red_valid(red_valid), .red_carry(red_carry), .red_sum(red_sum),
    .out_valid(out_valid), .out_y(out_y));

  fir_csd_transposed #(.W(W), .CPA_STAGES(1), .USE_CPA(1'b0)) byp_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .red_valid(b_red_valid), .red_carry(b_red_carry), .red_sum(b_red_sum),
    .out_valid(b_out_valid), .out_y(b_out_y));

  int     checks = 0;
  int     fails  = 0;
  string  cur_req = "R2";
  longint hist [5];
  longint exp_q [$];
  longint obs [0:63];
  int     obs_n = 0;
  logic [7:0] rv_sh = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint model_acc();
    return 402 * hist[0] + 3840 * hist[1] + 7900 * hist[2] + 3840 * hist[3] + 402 * hist[4];
  endfunction

  // Output monitor: R2 values, R5 latency, R9 bypass variant
  always @(negedge clk) begin
    if (rst) begin
      rv_sh = '0;
    end else begin
      chk(out_valid == rv_sh[CPA-1], "R5", longint'(out_valid), longint'(rv_sh[CPA-1]));
      rv_sh = {rv_sh[6:0], red_valid};
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_req, longint'($signed(out_y)), 0);
        end else begin
          longint e;
          e = exp_q.pop_front();
          chk(longint'($signed(out_y)) == e, cur_req, longint'($signed(out_y)), e);
          if (obs_n < 64) begin
            obs[obs_n] = longint'($signed(out_y));
            obs_n++;
          end
        end
      end
      chk(!b_out_valid && b_out_y == '0, "R9", longint'(b_out_y), 0);
      chk(b_red_carry + b_red_sum == red_carry + red_sum && b_red_valid == red_valid, "R9",
          longint'(b_red_carry + b_red_sum), longint'(red_carry + red_sum));
    end
  end

  // Called at a negedge; leaves in_valid high
  task automatic send_one(input int x);
    longint acc;
    logic [IW-1:0] tot;
    in_sample = x[W-1:0];
    in_valid  = 1'b1;
    for (int k = 4; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'($signed(x[W-1:0]));
    acc = model_acc();
    exp_q.push_back(acc >>> 14);
    @(posedge clk);
    @(negedge clk);
    chk(red_valid == 1'b1, "R5", longint'(red_valid), 1);
    tot = red_carry + red_sum;
    chk(tot == IW'(acc), "R6", longint'(tot), longint'(IW'(acc)));
  endtask

  task automatic idle(input int n);
    logic [IW-1:0] c0, s0;
    in_valid = 1'b0;
    c0 = red_carry;
    s0 = red_sum;
    for (int k = 0; k < n; k++) begin
      in_sample = W'($urandom);
      @(negedge clk);
    end
    chk(red_carry == c0 && red_sum == s0, "R4", longint'(red_carry + red_sum), longint'(c0 + s0));
    chk(red_valid == 1'b0, "R4", longint'(red_valid), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(red_carry == '0 && red_sum == '0, "R7", longint'(red_carry | red_sum), 0);
    chk(!red_valid && !out_valid && out_y == '0, "R7", longint'(out_y), 0);
    for (int k = 0; k < 5; k++) hist[k] = 0;
    exp_q.delete();
    obs_n = 0;
    rst = 1'b0;
  endtask

  task automatic test_impulse();
    longint coef [6] = '{402, 3840, 7900, 3840, 402, 0};
    cur_req = "R1";
    obs_n = 0;
    send_one(16384);
    for (int k = 0; k < 5; k++) send_one(0);
    idle(CPA + 2);
    chk(obs_n == 6, "R1", obs_n, 6);
    for (int k = 0; k < 6; k++) chk(obs[k] == coef[k], "R1", obs[k], coef[k]);
  endtask

  task automatic test_dc(input int v);
    cur_req = "R3";
    obs_n = 0;
    for (int k = 0; k < 8; k++) send_one(v);
    idle(CPA + 2);
    chk(obs[7] == longint'(v), "R3", obs[7], longint'(v));
  endtask

  task automatic test_extremes();
    cur_req = "R8";
    obs_n = 0;
    for (int k = 0; k < 6; k++) send_one(32767);
    for (int k = 0; k < 6; k++) send_one(-32768);
    for (int k = 0; k < 10; k++) send_one((k % 2 == 0) ? 32767 : -32768);
    idle(CPA + 2);
    chk(obs[5] == 32767, "R8", obs[5], 32767);
    chk(obs[11] == -32768, "R8", obs[11], -32768);
  endtask

  task automatic test_random(input int n);
    cur_req = "R2";
    for (int k = 0; k < n; k++) begin
      logic [15:0] r16;
      r16 = 16'($urandom);
      send_one(int'($signed(r16)));
      if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
    end
    idle(CPA + 2);
    chk(exp_q.size() == 0, "R2", exp_q.size(), 0);
  endtask

  task automatic test_mid_reset();
    cur_req = "R7";
    for (int k = 0; k < 4; k++) send_one(30000 - k * 9000);
    do_reset();
    test_impulse();
  endtask

  initial begin
    for (int k = 0; k < 5; k++) hist[k] = 0;
    @(negedge clk);
    do_reset();
    test_impulse();
    test_dc(-1234);
    test_dc(7777);
    test_extremes();
    test_random(300);
    test_mid_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule